// File: doc/BRIEF.md
# Write-Back MSI Snooping Cache Controller

This block is the coherence controller of one node on a shared, atomic snooping bus. It holds a small direct-mapped private write-back cache in which each line is invalid, shared (clean, read-only) or exclusive (dirty and the only copy, writable). It serves processor reads and writes and issues read-miss, write-miss and write-back transactions on the bus. It also watches every transaction that other nodes put on the bus. One block is one data word, so a miss fetches or claims a whole word.

Processor hits on a valid line finish locally in the cycle they are presented. Misses, and writes to shared lines, request the bus and hold the request until it is granted. A granted transaction completes in that cycle. If a miss evicts a dirty line, the victim moves into a one-entry write-back buffer. The miss goes on the bus first, and the write-back follows in a separate, later grant.

When another node's read miss or write miss hits a dirty copy, either in a line or in the write-back buffer, this node supplies the data in the same cycle and tells memory to abort its response. A snooped read miss downgrades an exclusive line to shared. A snooped write miss invalidates any copy.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, the write-back buffer is empty, and `bus_req`, `cpu_done` and `snp_supply` are 0.
- R2: A processor read of a block that is not present raises `bus_req` with `bus_cmd`=1 (read miss) and `bus_addr` equal to the address. In the granted cycle `cpu_done` is 1 and `cpu_rdata` equals `bus_rdata`, and the line becomes shared.
- R3: A processor write of a block that is not present issues `bus_cmd`=2 (write miss). The line becomes exclusive and holds the written data.
- R4: A processor write to a shared line is treated as a miss and issues `bus_cmd`=2. The line becomes exclusive, and later writes to it make no bus request.
- R5: Read hits on shared or exclusive lines and write hits on exclusive lines give `cpu_done`=1 in the cycle the request is presented, with `bus_req` low. A read hit returns the line's data.
- R6: A snooped read miss (`snp_cmd`=1) to an exclusive line gives `snp_supply`=1, `mem_abort`=1 and the line's data on `snp_data` in the same cycle. The line becomes shared, so a second snooped read miss is not supplied.
- R7: A snooped write miss (`snp_cmd`=2) to a shared or exclusive line invalidates it. An exclusive line first supplies its data with `mem_abort`=1, and a shared line supplies nothing.
- R8: A miss that evicts a dirty line issues its own read or write miss first. In a later grant it then issues `bus_cmd`=3 (write-back) with the victim's address on `bus_addr` and the victim's data on `bus_wdata`.
- R9: While a write-back waits for the bus, a snooped read miss to the victim address is supplied from the buffer with `mem_abort`=1.
- R10: An ungranted bus request keeps `bus_cmd` and `bus_addr` stable. Each grant completes exactly one transaction.
- R11: If another node's transaction targets the same line index in the cycle a processor hit is presented, the snoop takes effect first. The processor access does not complete in that cycle and is resolved afterwards against the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address of the block |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; a transaction completes when request and grant are both 1 |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back data |
| bus_rdata | input | DW | Block data returned in the granted cycle |
| snp_valid | input | 1 | Another node's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_supply | output | 1 | This node drives the block on `snp_data` |
| snp_data | output | DW | Supplied dirty data |
| mem_abort | output | 1 | Memory must not answer this transaction |

## Verification
The in-line assertions check the following on every cycle: request stability while ungranted, that a write-back request only starts right after a granted miss, that a completed access with no grant left the bus idle, that supply happens only for a snooped miss, and that the victim buffer is never overwritten while full. Only the directed scenarios can show the state-dependent outcomes. These are the line states after fills, upgrades, downgrades and invalidations, the data returned or supplied, the order of miss and write-back, and a processor hit deferred by a same-cycle snoop.

// File: rtl/msi_pkg.sv
// Shared encodings for the MSI snooping controller.
// Assumes: bus and snoop commands use the same two-bit code.
package msi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_MISS  = 2'd1,
        CT_WBACK = 2'd2
    } ctl_st_t;
endpackage

// File: rtl/msi_line_store.sv
// Direct-mapped line storage: state, tag and data per line.
// Two combinational read ports (processor side, snoop side), one full-line
// write port and one state-only port for snoop updates.
// Assumes: when both ports hit one line in a cycle, the snoop state wins.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_t         a_st,
    output logic [TAG_W-1:0] a_tag,
    output logic [DW-1:0]    a_data,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_t         b_st,
    output logic [TAG_W-1:0] b_tag,
    output logic [DW-1:0]    b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_st,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data,
    input  logic             sn_en,
    input  logic [IDX_W-1:0] sn_idx,
    input  line_st_t         sn_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_q   [LINES];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [DW-1:0]    data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // One line: full writes from the processor side, state overrides from snoops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= LN_INV;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    st_q[g]   <= wr_st;
                    tag_q[g]  <= wr_tag;
                    data_q[g] <= wr_data;
                end
                if (sn_en && sn_idx == IDX_W'(g)) begin
                    st_q[g] <= sn_st;
                end
            end
        end
    end

    // Read ports.
    always_comb begin
        a_st   = st_q[a_idx];
        a_tag  = tag_q[a_idx];
        a_data = data_q[a_idx];
        b_st   = st_q[b_idx];
        b_tag  = tag_q[b_idx];
        b_data = data_q[b_idx];
    end
endmodule

// File: rtl/msi_victim_buf.sv
// One-entry buffer for a dirty victim that waits for its write-back.
// Matches snooped addresses so the buffered copy can still be supplied.
// Assumes: the controller never loads it while it is full.
module msi_victim_buf #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          clear,
    input  logic [AW-1:0] cmp_addr,
    output logic          full,
    output logic          match,
    output logic [AW-1:0] vb_addr,
    output logic [DW-1:0] vb_data
);
    // Entry register: load takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            vb_addr <= '0;
            vb_data <= '0;
        end else if (load) begin
            full    <= 1'b1;
            vb_addr <= load_addr;
            vb_data <= load_data;
        end else if (clear) begin
            full <= 1'b0;
        end
    end

    // Address compare for snoops.
    assign match = full && (vb_addr == cmp_addr);

    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !full)
        else $error("victim buffer loaded while full");
endmodule

// File: rtl/msi_snoop_ctrl.sv
// Per-node write-back MSI snooping cache controller (direct-mapped, one word
// per block). Processor hits finish locally. Misses request an atomic bus and
// complete in the granted cycle. A dirty victim is written back in a later
// grant. Snoops of other nodes' misses are answered in the same cycle.
// Assumes: the processor holds its request until cpu_done; snp_valid is never
// high in a cycle in which this node is granted; arbitration is external.
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int IDX_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_supply,
    output logic [DW-1:0] snp_data,
    output logic          mem_abort
);
    localparam int TAG_W = AW - IDX_W;

    ctl_st_t ctl_q, ctl_d;

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tagin, s_tagin, c_tag, s_tag;
    line_st_t         c_st, s_st;
    logic [DW-1:0]    c_data, s_data;

    logic             wr_en, sn_en;
    line_st_t         wr_st, sn_st;
    logic [TAG_W-1:0] wr_tag;
    logic [DW-1:0]    wr_data;

    logic             vb_load, vb_clear, vb_full, vb_match;
    logic [AW-1:0]    vb_addr;
    logic [DW-1:0]    vb_data;

    logic     present, hit, conflict, accept, granted, s_hit, s_dirty, s_miss;
    bus_cmd_t scmd, miss_cmd;

    assign c_idx   = cpu_addr[IDX_W-1:0];
    assign c_tagin = cpu_addr[AW-1:IDX_W];
    assign s_idx   = snp_addr[IDX_W-1:0];
    assign s_tagin = snp_addr[AW-1:IDX_W];
    assign scmd    = bus_cmd_t'(snp_cmd);

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (c_idx),
        .a_st   (c_st),
        .a_tag  (c_tag),
        .a_data (c_data),
        .b_idx  (s_idx),
        .b_st   (s_st),
        .b_tag  (s_tag),
        .b_data (s_data),
        .wr_en  (wr_en),
        .wr_idx (c_idx),
        .wr_st  (wr_st),
        .wr_tag (wr_tag),
        .wr_data(wr_data),
        .sn_en  (sn_en),
        .sn_idx (s_idx),
        .sn_st  (sn_st)
    );

    msi_victim_buf #(.AW(AW), .DW(DW)) u_vbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (vb_load),
        .load_addr({c_tag, c_idx}),
        .load_data(c_data),
        .clear    (vb_clear),
        .cmp_addr (snp_addr),
        .full     (vb_full),
        .match    (vb_match),
        .vb_addr  (vb_addr),
        .vb_data  (vb_data)
    );

    // Snoop side: hit detection, supply of dirty data, state downgrade.
    always_comb begin
        s_miss     = snp_valid && (scmd == BC_RDMISS || scmd == BC_WRMISS);
        s_hit      = s_miss && (s_st != LN_INV) && (s_tag == s_tagin);
        s_dirty    = s_hit && (s_st == LN_EXC);
        snp_supply = s_dirty || (s_miss && vb_match);
        snp_data   = s_dirty ? s_data : vb_data;
        mem_abort  = snp_supply;
        sn_en      = s_hit && (scmd == BC_WRMISS || s_st == LN_EXC);
        sn_st      = (scmd == BC_WRMISS) ? LN_INV : LN_SHR;
        vb_clear   = (ctl_q == CT_WBACK && granted)
                     || (s_miss && vb_match && scmd == BC_WRMISS);
    end

    // Processor side: hit check, bus command, line writes, next control state.
    always_comb begin
        present   = (c_st != LN_INV) && (c_tag == c_tagin);
        hit       = present && (!cpu_we || c_st == LN_EXC);
        conflict  = snp_valid && (s_idx == c_idx);
        accept    = cpu_req && !conflict;
        miss_cmd  = cpu_we ? BC_WRMISS : BC_RDMISS;
        bus_req   = (ctl_q == CT_MISS) || (ctl_q == CT_WBACK && vb_full);
        granted   = bus_req && bus_gnt;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        cpu_done  = 1'b0;
        cpu_rdata = c_data;
        wr_en     = 1'b0;
        wr_st     = LN_INV;
        wr_tag    = c_tagin;
        wr_data   = cpu_wdata;
        vb_load   = 1'b0;
        ctl_d     = ctl_q;
        unique case (ctl_q)
            CT_IDLE: begin
                if (accept && hit) begin
                    cpu_done = 1'b1;
                    if (cpu_we) begin
                        wr_en = 1'b1;
                        wr_st = LN_EXC;
                    end
                end else if (accept) begin
                    ctl_d = CT_MISS;
                    if (c_st == LN_EXC && c_tag != c_tagin) begin
                        vb_load = 1'b1;
                        wr_en   = 1'b1;
                        wr_st   = LN_INV;
                        wr_tag  = c_tag;
                        wr_data = c_data;
                    end
                end
            end
            CT_MISS: begin
                bus_cmd  = miss_cmd;
                bus_addr = cpu_addr;
                if (granted) begin
                    cpu_done  = 1'b1;
                    cpu_rdata = bus_rdata;
                    wr_en     = 1'b1;
                    wr_st     = cpu_we ? LN_EXC : LN_SHR;
                    wr_data   = cpu_we ? cpu_wdata : bus_rdata;
                    ctl_d     = vb_full ? CT_WBACK : CT_IDLE;
                end
            end
            CT_WBACK: begin
                if (vb_full) begin
                    bus_cmd   = BC_WBACK;
                    bus_addr  = vb_addr;
                    bus_wdata = vb_data;
                end
                if (granted || !vb_full) ctl_d = CT_IDLE;
            end
            default: ctl_d = CT_IDLE;
        endcase
    end

    // Control state register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CT_IDLE;
        else        ctl_q <= ctl_d;
    end

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !(snp_valid && snp_cmd == 2'd2))
        |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)))
        else $error("ungranted request changed");

    a_r8_wback_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd3 && !$past(bus_req && bus_cmd == 2'd3))
        |-> $past(bus_req && bus_gnt && bus_cmd != 2'd3))
        else $error("write-back not preceded by granted miss");

    a_r5_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !bus_gnt) |-> !bus_req)
        else $error("local completion with bus request pending");

    a_r6_supply_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)))
        else $error("supply without snooped miss");
endmodule

// File: tb/msi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_test;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_supply, mem_abort;
    logic [DW-1:0] snp_data;

    logic [DW-1:0] mem [256];
    logic [1:0]    log_cmd  [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_n = 0;
    int            nvec = 0, nbad = 0;
    bit            finished = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_rdata = mem[bus_addr];

    msi_snoop_ctrl uut (.*);

    // Bus model: record granted transactions, memory absorbs write-backs.
    always @(posedge clk) begin
        if (rst_n && bus_req && bus_gnt) begin
            log_cmd[log_n]  <= bus_cmd;
            log_addr[log_n] <= bus_addr;
            log_data[log_n] <= bus_wdata;
            log_n <= log_n + 1;
            if (bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Processor access; grant is given after 'delay' requesting cycles.
    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int delay, output logic [DW-1:0] rd, output int cyc);
        int waitc = 0;
        bit got = 1'b0;
        cyc = -1;
        rd = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 40 && !got; i++) begin
            if (i > 0) @(negedge clk);
            bus_gnt = bus_req && (waitc >= delay);
            if (bus_req) waitc++;
            #1;
            if (cpu_done) begin got = 1'b1; rd = cpu_rdata; cyc = i; end
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
    endtask

    // One cycle of another node's transaction; samples the response.
    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         output logic sup, output logic ab, output logic [DW-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        sup = snp_supply; ab = mem_abort; d = snp_data;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // Grant a pending write-back.
    task automatic drain();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bus_gnt = bus_req;
        end
        @(negedge clk);
        bus_gnt = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 bus_req", bus_req, 0);
        check("R1 cpu_done", cpu_done, 0);
        check("R1 snp_supply", snp_supply, 0);
    endtask

    task automatic t_read_miss();
        logic [DW-1:0] rd; int cyc; int n0;
        n0 = log_n;
        cpu_op(1'b0, 8'h10, '0, 2, rd, cyc);
        check("R2 one transaction", log_n - n0, 1);
        check("R2 cmd", log_cmd[n0], 1);
        check("R2 addr", log_addr[n0], 8'h10);
        check("R2 data", rd, 16'hA5A5);
        check("R10 req drops after grant", bus_req, 0);
        n0 = log_n;
        cpu_op(1'b0, 8'h10, '0, 0, rd, cyc);
        check("R5 read hit same cycle", cyc, 0);
        check("R5 read hit no bus", log_n - n0, 0);
        check("R5 read hit data", rd, 16'hA5A5);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] rd; int cyc; int n0;
        n0 = log_n;
        cpu_op(1'b1, 8'h21, 16'h1234, 1, rd, cyc);
        check("R3 cmd", log_cmd[n0], 2);
        check("R3 addr", log_addr[n0], 8'h21);
        n0 = log_n;
        cpu_op(1'b0, 8'h21, '0, 0, rd, cyc);
        check("R3 exclusive data", rd, 16'h1234);
        check("R3 hit no bus", log_n - n0, 0);
    endtask

    task automatic t_upgrade();
        logic [DW-1:0] rd; int cyc; int n0;
        n0 = log_n;
        cpu_op(1'b1, 8'h10, 16'hBEEF, 0, rd, cyc);
        check("R4 write to shared is miss", log_n - n0, 1);
        check("R4 cmd", log_cmd[n0], 2);
        n0 = log_n;
        cpu_op(1'b1, 8'h10, 16'hCAFE, 0, rd, cyc);
        check("R4 second write no bus", log_n - n0, 0);
        check("R5 write hit same cycle", cyc, 0);
    endtask

    task automatic t_snoop_read();
        logic s, a; logic [DW-1:0] d, rd; int cyc; int n0;
        snoop(2'd1, 8'h10, s, a, d);
        check("R6 supply", s, 1);
        check("R6 abort", a, 1);
        check("R6 data", d, 16'hCAFE);
        snoop(2'd1, 8'h10, s, a, d);
        check("R6 shared not supplied", s, 0);
        n0 = log_n;
        cpu_op(1'b0, 8'h10, '0, 0, rd, cyc);
        check("R6 still readable", log_n - n0, 0);
        check("R6 read data", rd, 16'hCAFE);
        n0 = log_n;
        cpu_op(1'b1, 8'h10, 16'h0001, 0, rd, cyc);
        check("R6 downgraded write needs bus", log_n - n0, 1);
    endtask

    task automatic t_snoop_write();
        logic s, a; logic [DW-1:0] d, rd; int cyc; int n0;
        mem[8'h21] = 16'h0777;
        snoop(2'd2, 8'h21, s, a, d);
        check("R7 exclusive supply", s, 1);
        check("R7 exclusive abort", a, 1);
        check("R7 exclusive data", d, 16'h1234);
        n0 = log_n;
        cpu_op(1'b0, 8'h21, '0, 0, rd, cyc);
        check("R7 invalidated rereads", log_cmd[n0], 1);
        check("R7 refetched data", rd, 16'h0777);
        snoop(2'd2, 8'h21, s, a, d);
        check("R7 shared no supply", s, 0);
        n0 = log_n;
        cpu_op(1'b0, 8'h21, '0, 0, rd, cyc);
        check("R7 shared invalidated", log_n - n0, 1);
    endtask

    task automatic t_victim();
        logic s, a; logic [DW-1:0] d, rd; int cyc; int n0;
        cpu_op(1'b1, 8'h32, 16'h5555, 0, rd, cyc);
        n0 = log_n;
        cpu_op(1'b1, 8'h42, 16'h6666, 1, rd, cyc);
        check("R8 miss first", log_cmd[n0], 2);
        check("R8 miss addr", log_addr[n0], 8'h42);
        #1;
        check("R8 write-back pending", bus_req, 1);
        check("R8 write-back cmd", bus_cmd, 3);
        check("R8 write-back addr", bus_addr, 8'h32);
        snoop(2'd1, 8'h32, s, a, d);
        check("R9 buffer supply", s, 1);
        check("R9 buffer abort", a, 1);
        check("R9 buffer data", d, 16'h5555);
        drain();
        check("R8 one write-back", log_n - n0, 2);
        check("R8 write-back logged", log_cmd[n0+1], 3);
        check("R8 write-back data", log_data[n0+1], 16'h5555);
        check("R8 memory updated", mem[8'h32], 16'h5555);
        n0 = log_n;
        cpu_op(1'b0, 8'h52, '0, 0, rd, cyc);
        drain();
        check("R8 read miss before write-back", log_cmd[n0], 1);
        check("R8 read-evict write-back addr", log_addr[n0+1], 8'h42);
        check("R8 read-evict write-back data", log_data[n0+1], 16'h6666);
    endtask

    task automatic t_collision();
        logic [DW-1:0] rd; int cyc; int n0; logic s, dn; logic [DW-1:0] d;
        cpu_op(1'b1, 8'h13, 16'h0101, 0, rd, cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h13; cpu_wdata = 16'h0202;
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h13;
        #1;
        s = snp_supply; d = snp_data; dn = cpu_done;
        check("R11 snoop served first", s, 1);
        check("R11 old data supplied", d, 16'h0101);
        check("R11 cpu deferred", dn, 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0; cpu_req = 1'b0;
        n0 = log_n;
        cpu_op(1'b1, 8'h13, 16'h0202, 0, rd, cyc);
        check("R11 retried as write miss", log_cmd[n0], 2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = 16'hA5A5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_write_miss();
        t_upgrade();
        t_snoop_read();
        t_snoop_write();
        t_victim();
        t_collision();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            nvec++; nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule